// File: doc/BRIEF.md
# Asynchronous SRAM Pattern Test Sequencer

This block is a synchronous controller that exercises the pins of an external asynchronous static RAM and looks for faults in it. The RAM has an 11-bit address, an 8-bit data bus, two active-low chip enables and one active-low write strobe. The bus is split at the block's edge into an output value, a per-bit output enable and an input value, so the pad ring can build the bidirectional pin.

A one-cycle `start` request runs three fixed test groups back to back. The first group checks each data bit alone at location zero. The second writes and reads back a short thermometer pattern. The third checks that raising either chip enable blocks a write. Every read is compared against its expected value, and the controller keeps a sticky pass/fail flag per group along with the details of the first mismatch. Each pin step is held for a programmable number of clock cycles so that slow RAMs meet their setup and strobe widths. `done` pulses for one cycle when the run ends.

Top module: `sram_selftest_seq`

## Requirements
- R1: Out of reset and whenever no run is active, the address is 0, both enables and the write strobe are high (1), the output enable vector is 0 and `done` is 0.
- R2: A write operation walks six steps: address alone (all controls high, bus released); both enables low; data driven; write strobe low; write strobe high; enables high with the bus released. The address holds through all six.
- R3: A read operation walks four steps: address alone; both enables low; a second step with both enables low, at whose last cycle `ram_dq_in` is sampled; enables high. The output enable vector stays 0 throughout.
- R4: The single-bit group runs first, at address 0, for bit b = 0 up to 7: write 0, read, write 1, read. Only bit b is driven (`ram_dq_oe` = 1<<b) and only bit b is compared.
- R5: The pattern group writes 12 locations with all bits driven. Location k (k = 0..11) has address (1<<k)-1 and data taken in order from 00,01,03,07,0F,1F,3F,7F,FF,FE,FC,F8 (hex). It then reads the 12 locations in the same order.
- R6: The enable group writes 0x55 to address 0x555. It then runs a write of 0xFF with `ram_ce1_n` high and `ram_ce2_n` low, and reads back expecting 0x55. It then writes 0xAA to address 0x2AA, runs a write of 0xFF with `ram_ce2_n` high and `ram_ce1_n` low, and reads back expecting 0xAA.
- R7: Every step lasts `step_cycles` clock cycles, with 0 treated as 1. The value is captured in the cycle `start` is accepted, and later changes do not affect the run.
- R8: `grp_fail` bit 0 flags the single-bit group, bit 1 the pattern group and bit 2 the enable group. A flag is set by any mismatching read of its group, stays set to the end of the run, and is cleared when a new run is accepted.
- R9: At the first mismatch of a run, `err_valid` rises and `err_addr`, `err_exp` (expected AND compare mask) and `err_got` (read data AND compare mask) are captured. Later mismatches do not change them. All are cleared when a new run is accepted.
- R10: `start` is accepted only while idle. The first step appears on the pins in the cycle after acceptance. A `start` during a run or in the `done` cycle is ignored. `done` is high for exactly one cycle, directly after the last step, with the pins at their idle values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, sampled when idle |
| step_cycles | input | 8 | Cycles per pin step (0 acts as 1) |
| ram_addr | output | 11 | RAM address |
| ram_ce1_n | output | 1 | RAM first chip enable, active low |
| ram_ce2_n | output | 1 | RAM second chip enable, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_dq_out | output | 8 | Data driven towards the RAM |
| ram_dq_oe | output | 8 | Per-bit drive enable for the data bus |
| ram_dq_in | input | 8 | Data bus as seen from the RAM side |
| done | output | 1 | One-cycle end-of-run pulse |
| grp_fail | output | 3 | Sticky fail flag per test group |
| err_valid | output | 1 | A mismatch has been captured |
| err_addr | output | 11 | Address of the first mismatch |
| err_exp | output | 8 | Masked expected data of the first mismatch |
| err_got | output | 8 | Masked received data of the first mismatch |

## Verification
Two things can land in the same cycle: a new `start` request and the end of the current run. The bench raises `start` so that it is sampled exactly while `done` is high. In another run it raises `start` in the middle of the sequence. In both cases the per-cycle pin model expects idle pins after the `done` cycle and an undisturbed step sequence during the run, so an accepted request shows up at once as a pin mismatch. The behavioural RAM model injects stuck bits and an ignored enable, and the captured group flags and mismatch details are compared with values worked out from the requirements.

// File: rtl/sram_st_pkg.sv
package sram_st_pkg;
   typedef enum logic [2:0] {
      STP_ADDR, STP_CE, STP_DRIVE, STP_WLO, STP_WHI, STP_SAMP, STP_REL
   } step_e;

   typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_FIN} seq_e;

   localparam int unsigned N_GROUPS = 3;
   localparam int unsigned GRP_BIT  = 0;
   localparam int unsigned GRP_PAT  = 1;
   localparam int unsigned GRP_CE   = 2;
   localparam int unsigned CE_OPS   = 6;
endpackage

// File: rtl/sram_st_timer.sv
module sram_st_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] cfg,
   input  logic             run,
   output logic             tick
);
   logic [CNT_W-1:0] hold_q;
   logic [CNT_W-1:0] cnt_q;

   assign tick = run && (cnt_q == hold_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= CNT_W'(1);
         cnt_q  <= '0;
      end else if (load) begin
         hold_q <= (cfg == '0) ? CNT_W'(1) : cfg;
         cnt_q  <= '0;
      end else if (run) begin
         cnt_q  <= tick ? '0 : cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/sram_st_oprom.sv
module sram_st_oprom
   import sram_st_pkg::*;
#(
   parameter int AW   = 11,
   parameter int DW   = 8,
   parameter int OP_W = 6
) (
   input  logic [OP_W-1:0] idx,
   output logic            op_wr,
   output logic [AW-1:0]   op_addr,
   output logic [DW-1:0]   op_data,
   output logic [DW-1:0]   op_mask,
   output logic            op_ce1_n,
   output logic            op_ce2_n,
   output logic [1:0]      op_grp
);
   localparam int unsigned N_BIT = 4 * DW;
   localparam int unsigned N_PAT = AW + 1;

   function automatic logic [AW-1:0] ones_a(input int k);
      logic [AW-1:0] r;
      for (int i = 0; i < AW; i++) r[i] = (i < k);
      return r;
   endfunction

   function automatic logic [DW-1:0] thermo_d(input int k);
      logic [DW-1:0] r;
      for (int i = 0; i < DW; i++) r[i] = (k <= DW) ? (i < k) : (i >= k - DW);
      return r;
   endfunction

   function automatic logic [AW-1:0] alt_a(input logic odd);
      logic [AW-1:0] r;
      for (int i = 0; i < AW; i++) r[i] = (((i % 2) == 1) == odd);
      return r;
   endfunction

   function automatic logic [DW-1:0] alt_d(input logic odd);
      logic [DW-1:0] r;
      for (int i = 0; i < DW; i++) r[i] = (((i % 2) == 1) == odd);
      return r;
   endfunction

   int unsigned li, lj, lk, lc;
   logic        second;

   always_comb begin
      li       = 32'(idx);
      lj       = 0;
      lk       = 0;
      lc       = 0;
      second   = 1'b0;
      op_wr    = 1'b0;
      op_addr  = '0;
      op_data  = '0;
      op_mask  = '1;
      op_ce1_n = 1'b0;
      op_ce2_n = 1'b0;
      op_grp   = 2'(GRP_BIT);
      if (li < N_BIT) begin
         // per bit: write 0, read, write 1, read
         lk      = li % 4;
         op_wr   = (lk % 2) == 0;
         op_mask = DW'(1) << (li / 4);
         op_data = (lk >= 2) ? op_mask : '0;
      end else if (li < N_BIT + 2 * N_PAT) begin
         lj      = li - N_BIT;
         op_wr   = lj < N_PAT;
         lk      = op_wr ? lj : lj - N_PAT;
         op_addr = ones_a(int'(lk));
         op_data = thermo_d(int'(lk));
         op_grp  = 2'(GRP_PAT);
      end else begin
         lc      = li - N_BIT - 2 * N_PAT;
         second  = lc >= 3;
         lk      = lc % 3;
         op_wr   = lk != 2;
         op_addr = alt_a(second);
         op_data = (lk == 1) ? '1 : alt_d(second);
         if (lk == 1) begin
            op_ce1_n = !second;
            op_ce2_n = second;
         end
         op_grp  = 2'(GRP_CE);
      end
   end
endmodule

// File: rtl/sram_st_cmp.sv
module sram_st_cmp
   import sram_st_pkg::*;
#(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                sample,
   input  logic [1:0]          grp,
   input  logic [AW-1:0]       addr,
   input  logic [DW-1:0]       exp_d,
   input  logic [DW-1:0]       mask,
   input  logic [DW-1:0]       got,
   output logic [N_GROUPS-1:0] fail,
   output logic                err_valid,
   output logic [AW-1:0]       err_addr,
   output logic [DW-1:0]       err_exp,
   output logic [DW-1:0]       err_got
);
   logic mism;
   assign mism = sample && (((got ^ exp_d) & mask) != '0);

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     flag_q <= 1'b0;
         else if (clr)                   flag_q <= 1'b0;
         else if (mism && grp == 2'(g))  flag_q <= 1'b1;
      end
      assign fail[g] = flag_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_valid <= 1'b0;
         err_addr  <= '0;
         err_exp   <= '0;
         err_got   <= '0;
      end else if (clr) begin
         err_valid <= 1'b0;
         err_addr  <= '0;
         err_exp   <= '0;
         err_got   <= '0;
      end else if (mism && !err_valid) begin
         err_valid <= 1'b1;
         err_addr  <= addr;
         err_exp   <= exp_d & mask;
         err_got   <= got & mask;
      end
   end
endmodule

// File: rtl/sram_selftest_seq.sv
module sram_selftest_seq
   import sram_st_pkg::*;
#(
   parameter int AW    = 11,
   parameter int DW    = 8,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] step_cycles,
   output logic [AW-1:0]    ram_addr,
   output logic             ram_ce1_n,
   output logic             ram_ce2_n,
   output logic             ram_we_n,
   output logic [DW-1:0]    ram_dq_out,
   output logic [DW-1:0]    ram_dq_oe,
   input  logic [DW-1:0]    ram_dq_in,
   output logic             done,
   output logic [2:0]       grp_fail,
   output logic             err_valid,
   output logic [AW-1:0]    err_addr,
   output logic [DW-1:0]    err_exp,
   output logic [DW-1:0]    err_got
);
   localparam int unsigned N_OPS   = 4 * DW + 2 * (AW + 1) + CE_OPS;
   localparam int          OP_W    = $clog2(N_OPS);
   localparam logic [OP_W-1:0] LAST_OP = OP_W'(N_OPS - 1);

   if (AW < 2 || DW < 2 || AW >= 2 * DW || CNT_W < 1) begin : g_bad_cfg
      $error("sram_selftest_seq: unsupported AW/DW/CNT_W combination");
   end

   seq_e            seq_q;
   step_e           step_q, step_nxt;
   logic [OP_W-1:0] op_q;
   logic            accept, running, tick, sample;

   logic            op_wr, op_ce1_n, op_ce2_n;
   logic [AW-1:0]   op_addr;
   logic [DW-1:0]   op_data, op_mask;
   logic [1:0]      op_grp;

   assign accept  = (seq_q == SQ_IDLE) && start;
   assign running = (seq_q == SQ_RUN);
   assign sample  = running && tick && (step_q == STP_SAMP);
   assign done    = (seq_q == SQ_FIN);

   sram_st_timer #(.CNT_W(CNT_W)) timer_i (
      .clk(clk), .rst_n(rst_n), .load(accept), .cfg(step_cycles),
      .run(running), .tick(tick)
   );

   sram_st_oprom #(.AW(AW), .DW(DW), .OP_W(OP_W)) oprom_i (
      .idx(op_q), .op_wr(op_wr), .op_addr(op_addr), .op_data(op_data),
      .op_mask(op_mask), .op_ce1_n(op_ce1_n), .op_ce2_n(op_ce2_n),
      .op_grp(op_grp)
   );

   sram_st_cmp #(.AW(AW), .DW(DW)) cmp_i (
      .clk(clk), .rst_n(rst_n), .clr(accept), .sample(sample),
      .grp(op_grp), .addr(op_addr), .exp_d(op_data), .mask(op_mask),
      .got(ram_dq_in), .fail(grp_fail), .err_valid(err_valid),
      .err_addr(err_addr), .err_exp(err_exp), .err_got(err_got)
   );

   always_comb begin
      unique case (step_q)
         STP_ADDR:  step_nxt = STP_CE;
         STP_CE:    step_nxt = op_wr ? STP_DRIVE : STP_SAMP;
         STP_DRIVE: step_nxt = STP_WLO;
         STP_WLO:   step_nxt = STP_WHI;
         default:   step_nxt = STP_REL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q  <= SQ_IDLE;
         op_q   <= '0;
         step_q <= STP_ADDR;
      end else begin
         unique case (seq_q)
            SQ_IDLE: if (start) begin
               seq_q  <= SQ_RUN;
               op_q   <= '0;
               step_q <= STP_ADDR;
            end
            SQ_RUN: if (tick) begin
               if (step_q == STP_REL) begin
                  step_q <= STP_ADDR;
                  if (op_q == LAST_OP) seq_q <= SQ_FIN;
                  else                 op_q  <= op_q + OP_W'(1);
               end else begin
                  step_q <= step_nxt;
               end
            end
            default: seq_q <= SQ_IDLE;
         endcase
      end
   end

   // pin decode from registered sequencer state
   always_comb begin
      ram_addr   = '0;
      ram_ce1_n  = 1'b1;
      ram_ce2_n  = 1'b1;
      ram_we_n   = 1'b1;
      ram_dq_out = '0;
      ram_dq_oe  = '0;
      if (running) begin
         ram_addr = op_addr;
         unique case (step_q)
            STP_CE, STP_SAMP: begin
               ram_ce1_n = op_ce1_n;
               ram_ce2_n = op_ce2_n;
            end
            STP_DRIVE, STP_WLO, STP_WHI: begin
               ram_ce1_n  = op_ce1_n;
               ram_ce2_n  = op_ce2_n;
               ram_we_n   = (step_q != STP_WLO);
               ram_dq_out = op_data & op_mask;
               ram_dq_oe  = op_mask;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/sram_st_chk.sv
module sram_st_chk #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] ram_addr,
   input logic          ram_ce1_n,
   input logic          ram_ce2_n,
   input logic          ram_we_n,
   input logic [DW-1:0] ram_dq_oe,
   input logic          done
);
   // R2
   we_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (!ram_ce1_n || !ram_ce2_n));

   // R2
   we_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (ram_dq_oe != '0));

   // R2
   we_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_we_n) |-> ($past(ram_dq_oe) != '0));

   // R3
   drive_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_dq_oe != '0) |-> (!ram_ce1_n || !ram_ce2_n));

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!ram_ce1_n || !ram_ce2_n) && $past(!ram_ce1_n || !ram_ce2_n))
      |-> $stable(ram_addr));

   // R4
   mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ram_dq_oe) || (ram_dq_oe == '1));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R1
   idle_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ram_addr == '0 && ram_ce1_n && ram_ce2_n && ram_we_n
                && ram_dq_oe == '0));
endmodule

bind sram_selftest_seq sram_st_chk #(.AW(AW), .DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .ram_addr(ram_addr), .ram_ce1_n(ram_ce1_n),
   .ram_ce2_n(ram_ce2_n), .ram_we_n(ram_we_n), .ram_dq_oe(ram_dq_oe),
   .done(done)
);

// File: tb/sram_selftest_seq_tb.sv
module sram_selftest_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  step_cycles = 8'd1;
   logic [10:0] ram_addr;
   logic        ram_ce1_n, ram_ce2_n, ram_we_n;
   logic [7:0]  ram_dq_out, ram_dq_oe, ram_dq_in;
   logic        done;
   logic [2:0]  grp_fail;
   logic        err_valid;
   logic [10:0] err_addr;
   logic [7:0]  err_exp, err_got;

   int n_chk = 0;
   int n_fail = 0;
   bit cmp_en = 1'b0;

   always #4 clk = ~clk;

   sram_selftest_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .step_cycles(step_cycles),
      .ram_addr(ram_addr), .ram_ce1_n(ram_ce1_n), .ram_ce2_n(ram_ce2_n),
      .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
      .ram_dq_in(ram_dq_in), .done(done), .grp_fail(grp_fail),
      .err_valid(err_valid), .err_addr(err_addr), .err_exp(err_exp),
      .err_got(err_got)
   );

   // behavioural RAM with fault injection
   localparam logic [7:0] FLOAT = 8'h96;
   logic [7:0] mem [0:2047];
   int         flt_addr = -1;
   logic [7:0] flt_or = 8'h00;
   bit         ign_ce1 = 1'b0;
   logic       sel;

   initial for (int i = 0; i < 2048; i++) mem[i] = 8'h00;

   always_comb begin
      sel = ign_ce1 ? !ram_ce2_n : (!ram_ce1_n && !ram_ce2_n);
      if (sel && ram_we_n)
         ram_dq_in = mem[ram_addr] | ((int'(ram_addr) == flt_addr) ? flt_or : 8'h00);
      else
         ram_dq_in = FLOAT;
   end

   always @(posedge clk)
      if (sel && !ram_we_n)
         mem[ram_addr] <= (ram_dq_out & ram_dq_oe) | (FLOAT & ~ram_dq_oe);

   // per-cycle expected pin trace
   typedef struct packed {
      logic [10:0] a;
      logic        c1, c2, we;
      logic [7:0]  oe, dq;
      logic        dn;
   } pin_t;

   localparam pin_t IDLE = '{a: 11'h0, c1: 1'b1, c2: 1'b1, we: 1'b1,
                             oe: 8'h0, dq: 8'h0, dn: 1'b0};
   pin_t  exp_q[$];
   string tag_q[$];
   pin_t  cur_e;
   string cur_t;
   int    hold = 1;

   task automatic push(input logic [10:0] a, input logic c1, c2, we,
                       input logic [7:0] oe, dq, input logic dn, input string t);
      for (int r = 0; r < hold; r++) begin
         exp_q.push_back('{a: a, c1: c1, c2: c2, we: we, oe: oe, dq: dq, dn: dn});
         tag_q.push_back(t);
      end
   endtask

   task automatic op_write(input logic [10:0] a, input logic [7:0] d, m,
                           input logic c1, c2, input string t);
      push(a, 1, 1, 1, 0, 0, 0, t);
      push(a, c1, c2, 1, 0, 0, 0, t);
      push(a, c1, c2, 1, m, d, 0, t);
      push(a, c1, c2, 0, m, d, 0, t);
      push(a, c1, c2, 1, m, d, 0, t);
      push(a, 1, 1, 1, 0, 0, 0, t);
   endtask

   task automatic op_read(input logic [10:0] a, input string t);
      push(a, 1, 1, 1, 0, 0, 0, t);
      push(a, 0, 0, 1, 0, 0, 0, t);
      push(a, 0, 0, 1, 0, 0, 0, t);
      push(a, 1, 1, 1, 0, 0, 0, t);
   endtask

   task automatic build_trace();
      logic [7:0] pat [12] = '{8'h00, 8'h01, 8'h03, 8'h07, 8'h0F, 8'h1F,
                               8'h3F, 8'h7F, 8'hFF, 8'hFE, 8'hFC, 8'hF8};
      exp_q.push_back(IDLE);
      tag_q.push_back("R10");
      for (int b = 0; b < 8; b++) begin
         op_write(11'h0, 8'h00, 8'(1 << b), 0, 0, "R4");
         op_read(11'h0, "R4");
         op_write(11'h0, 8'(1 << b), 8'(1 << b), 0, 0, "R4");
         op_read(11'h0, "R4");
      end
      for (int k = 0; k < 12; k++) op_write(11'((1 << k) - 1), pat[k], 8'hFF, 0, 0, "R5");
      for (int k = 0; k < 12; k++) op_read(11'((1 << k) - 1), "R5");
      op_write(11'h555, 8'h55, 8'hFF, 0, 0, "R6");
      op_write(11'h555, 8'hFF, 8'hFF, 1, 0, "R6");
      op_read(11'h555, "R6");
      op_write(11'h2AA, 8'hAA, 8'hFF, 0, 0, "R6");
      op_write(11'h2AA, 8'hFF, 8'hFF, 0, 1, "R6");
      op_read(11'h2AA, "R6");
      exp_q.push_back('{a: 11'h0, c1: 1'b1, c2: 1'b1, we: 1'b1,
                        oe: 8'h0, dq: 8'h0, dn: 1'b1});
      tag_q.push_back("R10");
   endtask

   task automatic check(input bit ok, input string t, input string what,
                        input logic [31:0] got, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", t, what, got, expv);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en) begin
         if (exp_q.size() > 0) begin
            cur_e = exp_q.pop_front();
            cur_t = tag_q.pop_front();
         end else begin
            cur_e = IDLE;
            cur_t = "R1";
         end
         n_chk++;
         if (ram_addr !== cur_e.a || ram_ce1_n !== cur_e.c1 || ram_ce2_n !== cur_e.c2 ||
             ram_we_n !== cur_e.we || ram_dq_oe !== cur_e.oe ||
             (ram_dq_out & cur_e.oe) !== (cur_e.dq & cur_e.oe) || done !== cur_e.dn) begin
            n_fail++;
            $display("FAIL %s pins: got a=%h ce=%b%b we=%b oe=%h dq=%h done=%b expected a=%h ce=%b%b we=%b oe=%h dq=%h done=%b",
                     cur_t, ram_addr, ram_ce1_n, ram_ce2_n, ram_we_n, ram_dq_oe,
                     ram_dq_out & cur_e.oe, done, cur_e.a, cur_e.c1, cur_e.c2,
                     cur_e.we, cur_e.oe, cur_e.dq & cur_e.oe, cur_e.dn);
         end
      end
   end

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic run_test(input int cfg, input int f_addr, input logic [7:0] f_or,
                           input bit ign, input bit mid_start, input bit done_start,
                           input logic [2:0] x_fail, input bit x_ev,
                           input logic [10:0] x_ea, input logic [7:0] x_ee, x_eg);
      int len;
      @(posedge clk); #1;
      flt_addr    = f_addr;
      flt_or      = f_or;
      ign_ce1     = ign;
      step_cycles = 8'(cfg);
      hold        = (cfg == 0) ? 1 : cfg;
      build_trace();
      len   = exp_q.size() - 1;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      step_cycles = 8'(cfg + 5); // R7: change after acceptance has no effect
      for (int c = 2; c <= len; c++) begin
         @(posedge clk); #1;
         start = (mid_start && c == len / 2) || (done_start && c == len);
      end
      @(posedge clk); #1;
      start = 1'b0;
      repeat (4) @(posedge clk);
      #2;
      check(grp_fail == x_fail, "R8", "grp_fail", 32'(grp_fail), 32'(x_fail));
      check(err_valid == x_ev, "R9", "err_valid", 32'(err_valid), 32'(x_ev));
      if (x_ev) begin
         check(err_addr == x_ea, "R9", "err_addr", 32'(err_addr), 32'(x_ea));
         check(err_exp == x_ee, "R9", "err_exp", 32'(err_exp), 32'(x_ee));
         check(err_got == x_eg, "R9", "err_got", 32'(err_got), 32'(x_eg));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cmp_en = 1'b1;
      @(posedge clk); #2;
      check(done == 1'b0, "R1", "done", 32'(done), 32'h0);
      check(grp_fail == 3'b000, "R1", "grp_fail", 32'(grp_fail), 32'h0);
      check(err_valid == 1'b0, "R1", "err_valid", 32'(err_valid), 32'h0);
      repeat (3) @(posedge clk);
      // R5 R6: fault-free RAM, one cycle per step
      run_test(1, -1, 8'h00, 0, 0, 0, 3'b000, 0, 11'h0, 8'h00, 8'h00);
      // R4: bit 2 of address 0 stuck high, 3 cycles per step, start mid-run (R10)
      run_test(3, 0, 8'h04, 0, 1, 0, 3'b011, 1, 11'h000, 8'h00, 8'h04);
      // R6: first enable ignored by the RAM, step_cycles 0 acts as 1 (R7), start in done cycle (R10)
      run_test(0, -1, 8'h00, 1, 0, 1, 3'b100, 1, 11'h555, 8'h55, 8'hFF);
      // R5: bit 0 of the top pattern address stuck high, 2 cycles per step
      run_test(2, 11'h7FF, 8'h01, 0, 0, 0, 3'b010, 1, 11'h7FF, 8'hF8, 8'hF9);
      // R8 R9: a clean run after failing runs clears the flags and capture
      run_test(1, -1, 8'h00, 0, 0, 0, 3'b000, 0, 11'h0, 8'h00, 8'h00);
      repeat (4) @(posedge clk);
      summary();
      $finish;
   end
endmodule